// File: doc/BRIEF.md
# Data toggle synchronization tracker

This block keeps the DATA0/DATA1 sequence state for one bidirectional endpoint. That endpoint is either a device endpoint pair or the host's send/receive pair. It holds two toggles. The expected-receive toggle is the value the next incoming data packet should carry. The transmit toggle is the value the next outgoing data packet will carry. Software can load both toggles at any time through a configuration write strobe. The same write also sets the automatic-flip enables, the no-handshake (isochronous) options and the double-buffer options.

A packet engine outside this block reports each completed transaction with a strobe and its outcome. For a received packet, the block compares the packet's toggle with the expected toggle. It registers the result as a match flag, which holds until the next packet ends. If automatic flipping is enabled, a toggle inverts only after a successful transaction:
- a matched, accepted reception;
- a send that got an ACK, or a send in no-handshake mode.

For outgoing packets the block supplies the DATA PID code. For each direction it supplies the offset of the buffer half chosen by the toggle.

Top module: `dtog_tracker`

## Requirements
- R1: After reset, both toggles, both auto-flip enables, both no-handshake bits, both double-buffer bits and the match flag are 0. Both toggle values encode 0 as DATA0 and 1 as DATA1.
- R2: A cycle with `cfg_we_i` high loads all configuration fields (toggles, auto enables, no-handshake bits, double-buffer bits). The new values appear on the outputs after the next clock edge.
- R3: On a cycle with `rx_done_i` high, `tog_ok_o` becomes 1 after the edge if `rx_pid_odd_i` (0 = DATA0, 1 = DATA1) equals the expected-receive toggle, and 0 otherwise. On cycles without `rx_done_i`, `tog_ok_o` keeps its value.
- R4: The expected-receive toggle inverts only when all of these hold in the same cycle: `rx_done_i` is high, `rx_accept_i` is high, the toggles match, and the receive auto enable is 1. A mismatch, a rejected packet or a disabled auto enable leaves it unchanged.
- R5: The transmit toggle inverts on `tx_done_i` when the transmit auto enable is 1 and either `tx_res_i` is 2'b00 (ACK) or transmit no-handshake is set. The result codes 2'b01 (NAK), 2'b10 (STALL) and 2'b11 (timeout) leave it unchanged when no-handshake is clear.
- R6: `tx_pid_o` is 4'b0011 (DATA0) while the transmit toggle is 0, and 4'b1011 (DATA1) while it is 1.
- R7: `rx_ack_en_o` is the inverse of the receive no-handshake bit, and `tx_ack_wait_o` is the inverse of the transmit no-handshake bit.
- R8: For each direction, the buffer offset is BUF_BYTES when the double-buffer bit and the toggle are both 1, and 0 otherwise.
- R9: A configuration write in the same cycle as a successful transaction wins: the written toggle values are loaded and no flip occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_rx_tog_i | input | 1 | Expected-receive toggle to load |
| cfg_tx_tog_i | input | 1 | Transmit toggle to load |
| cfg_rx_auto_i | input | 1 | Receive auto-flip enable to load |
| cfg_tx_auto_i | input | 1 | Transmit auto-flip enable to load |
| cfg_rx_nohs_i | input | 1 | Receive no-handshake bit to load |
| cfg_tx_nohs_i | input | 1 | Transmit no-handshake bit to load |
| cfg_rx_dbl_i | input | 1 | Receive double-buffer bit to load |
| cfg_tx_dbl_i | input | 1 | Transmit double-buffer bit to load |
| rx_done_i | input | 1 | Received data packet ended |
| rx_pid_odd_i | input | 1 | Toggle of the received packet (1 = DATA1) |
| rx_accept_i | input | 1 | Engine accepted the received data |
| tx_done_i | input | 1 | Send transaction ended |
| tx_res_i | input | 2 | Send outcome: 00 ACK, 01 NAK, 10 STALL, 11 timeout |
| rx_tog_o | output | 1 | Expected-receive toggle |
| tx_tog_o | output | 1 | Transmit toggle |
| tog_ok_o | output | 1 | Match flag of the last received packet |
| tx_pid_o | output | 4 | DATA PID for the next outgoing packet |
| rx_ack_en_o | output | 1 | Receive side answers with a handshake |
| tx_ack_wait_o | output | 1 | Send side waits for a handshake |
| rx_buf_off_o | output | OFF_W | Receive buffer half offset |
| tx_buf_off_o | output | OFF_W | Transmit buffer half offset |

## Verification
The assertions assume that every strobe is a single-cycle pulse sampled at the clock edge. They also assume that `rx_pid_odd_i`, `rx_accept_i` and `tx_res_i` are meaningful only in cycles where their strobe is high. The bench drives each strobe for exactly one cycle at a time, with its qualifiers set in that same cycle and cleared to idle afterwards. It sweeps every combination of initial toggle, auto enable, packet toggle, acceptance, no-handshake bit and send outcome. One deliberate overlap of a configuration write with successful transactions exercises the write-priority rule.

// File: rtl/dtog_pkg.sv
package dtog_pkg;
  typedef enum logic [1:0] {
    TXR_ACK   = 2'b00,
    TXR_NAK   = 2'b01,
    TXR_STALL = 2'b10,
    TXR_TMO   = 2'b11
  } tx_res_e;

  localparam logic [3:0] PID_DATA0 = 4'b0011;
  localparam logic [3:0] PID_DATA1 = 4'b1011;

  localparam int unsigned DIR_RX = 0;
  localparam int unsigned DIR_TX = 1;
  localparam int unsigned N_DIR  = 2;

  function automatic logic [3:0] data_pid(input logic tog);
    return tog ? PID_DATA1 : PID_DATA0;
  endfunction
endpackage

// File: rtl/dtog_dir.sv
// Per-direction toggle state: software load has priority over auto flip.
module dtog_dir #(
  parameter int unsigned BUF_BYTES = 64,
  localparam int unsigned OFF_W = $clog2(2 * BUF_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_tog_i,
  input  logic             cfg_auto_i,
  input  logic             cfg_nohs_i,
  input  logic             cfg_dbl_i,
  input  logic             ok_i,
  output logic             tog_o,
  output logic             auto_o,
  output logic             nohs_o,
  output logic [OFF_W-1:0] buf_off_o
);
  logic tog_q, auto_q, nohs_q, dbl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q  <= 1'b0;
      auto_q <= 1'b0;
      nohs_q <= 1'b0;
      dbl_q  <= 1'b0;
    end else if (cfg_we_i) begin
      tog_q  <= cfg_tog_i;
      auto_q <= cfg_auto_i;
      nohs_q <= cfg_nohs_i;
      dbl_q  <= cfg_dbl_i;
    end else if (ok_i && auto_q) begin
      tog_q <= ~tog_q;
    end
  end

  assign tog_o     = tog_q;
  assign auto_o    = auto_q;
  assign nohs_o    = nohs_q;
  assign buf_off_o = (dbl_q && tog_q) ? OFF_W'(BUF_BYTES) : '0;
endmodule

// File: rtl/dtog_rx_cmp.sv
// Received-packet toggle comparison; match flag held between packets.
module dtog_rx_cmp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_done_i,
  input  logic rx_pid_odd_i,
  input  logic rx_accept_i,
  input  logic exp_tog_i,
  output logic tog_ok_o,
  output logic ok_o
);
  logic match;
  logic tog_ok_q;

  assign match = (rx_pid_odd_i == exp_tog_i);
  assign ok_o  = rx_done_i && rx_accept_i && match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tog_ok_q <= 1'b0;
    else if (rx_done_i) tog_ok_q <= match;
  end

  assign tog_ok_o = tog_ok_q;
endmodule

// File: rtl/dtog_tx_judge.sv
// Send success: ACK, or any completion when no handshake is expected.
module dtog_tx_judge
  import dtog_pkg::*;
(
  input  logic    tx_done_i,
  input  tx_res_e tx_res_i,
  input  logic    nohs_i,
  output logic    ok_o
);
  assign ok_o = tx_done_i && (nohs_i || (tx_res_i == TXR_ACK));
endmodule

// File: rtl/dtog_tracker.sv
module dtog_tracker
  import dtog_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 64,
  localparam int unsigned OFF_W = $clog2(2 * BUF_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_rx_tog_i,
  input  logic             cfg_tx_tog_i,
  input  logic             cfg_rx_auto_i,
  input  logic             cfg_tx_auto_i,
  input  logic             cfg_rx_nohs_i,
  input  logic             cfg_tx_nohs_i,
  input  logic             cfg_rx_dbl_i,
  input  logic             cfg_tx_dbl_i,
  input  logic             rx_done_i,
  input  logic             rx_pid_odd_i,
  input  logic             rx_accept_i,
  input  logic             tx_done_i,
  input  logic [1:0]       tx_res_i,
  output logic             rx_tog_o,
  output logic             tx_tog_o,
  output logic             tog_ok_o,
  output logic [3:0]       tx_pid_o,
  output logic             rx_ack_en_o,
  output logic             tx_ack_wait_o,
  output logic [OFF_W-1:0] rx_buf_off_o,
  output logic [OFF_W-1:0] tx_buf_off_o
);
  logic [N_DIR-1:0] cfg_tog, cfg_auto, cfg_nohs, cfg_dbl;
  logic [N_DIR-1:0] dir_ok, dir_tog, dir_auto, dir_nohs;
  logic [OFF_W-1:0] dir_off [N_DIR];

  assign cfg_tog[DIR_RX]  = cfg_rx_tog_i;
  assign cfg_tog[DIR_TX]  = cfg_tx_tog_i;
  assign cfg_auto[DIR_RX] = cfg_rx_auto_i;
  assign cfg_auto[DIR_TX] = cfg_tx_auto_i;
  assign cfg_nohs[DIR_RX] = cfg_rx_nohs_i;
  assign cfg_nohs[DIR_TX] = cfg_tx_nohs_i;
  assign cfg_dbl[DIR_RX]  = cfg_rx_dbl_i;
  assign cfg_dbl[DIR_TX]  = cfg_tx_dbl_i;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    dtog_dir #(.BUF_BYTES(BUF_BYTES)) i_dir (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we_i),
      .cfg_tog_i  (cfg_tog[d]),
      .cfg_auto_i (cfg_auto[d]),
      .cfg_nohs_i (cfg_nohs[d]),
      .cfg_dbl_i  (cfg_dbl[d]),
      .ok_i       (dir_ok[d]),
      .tog_o      (dir_tog[d]),
      .auto_o     (dir_auto[d]),
      .nohs_o     (dir_nohs[d]),
      .buf_off_o  (dir_off[d])
    );
  end

  dtog_rx_cmp i_rx_cmp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_done_i    (rx_done_i),
    .rx_pid_odd_i (rx_pid_odd_i),
    .rx_accept_i  (rx_accept_i),
    .exp_tog_i    (dir_tog[DIR_RX]),
    .tog_ok_o     (tog_ok_o),
    .ok_o         (dir_ok[DIR_RX])
  );

  dtog_tx_judge i_tx_judge (
    .tx_done_i (tx_done_i),
    .tx_res_i  (tx_res_e'(tx_res_i)),
    .nohs_i    (dir_nohs[DIR_TX]),
    .ok_o      (dir_ok[DIR_TX])
  );

  assign rx_tog_o      = dir_tog[DIR_RX];
  assign tx_tog_o      = dir_tog[DIR_TX];
  assign tx_pid_o      = data_pid(dir_tog[DIR_TX]);
  assign rx_ack_en_o   = ~dir_nohs[DIR_RX];
  assign tx_ack_wait_o = ~dir_nohs[DIR_TX];
  assign rx_buf_off_o  = dir_off[DIR_RX];
  assign tx_buf_off_o  = dir_off[DIR_TX];
endmodule

// File: rtl/dtog_tracker_chk.sv
module dtog_tracker_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_we_i,
  input logic       cfg_rx_tog_i,
  input logic       cfg_tx_tog_i,
  input logic       rx_done_i,
  input logic       rx_pid_odd_i,
  input logic       rx_accept_i,
  input logic       tx_done_i,
  input logic [1:0] tx_res_i,
  input logic       rx_auto_i,
  input logic       tx_auto_i,
  input logic       tx_nohs_i,
  input logic       rx_tog_o,
  input logic       tx_tog_o,
  input logic       tog_ok_o
);
  logic rx_win, tx_win;
  assign rx_win = rx_done_i && rx_accept_i && (rx_pid_odd_i == rx_tog_o);
  assign tx_win = tx_done_i && (tx_nohs_i || tx_res_i == 2'b00);

  AST_MATCH_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_i |=> tog_ok_o == ($past(rx_pid_odd_i) == $past(rx_tog_o))); // R3
  AST_MATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_done_i |=> $stable(tog_ok_o)); // R3
  AST_RX_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i && rx_win && rx_auto_i) |=> rx_tog_o != $past(rx_tog_o)); // R4
  AST_RX_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i && !(rx_win && rx_auto_i)) |=> $stable(rx_tog_o)); // R4
  AST_TX_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i && tx_win && tx_auto_i) |=> tx_tog_o != $past(tx_tog_o)); // R5
  AST_TX_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i && !(tx_win && tx_auto_i)) |=> $stable(tx_tog_o)); // R5
  AST_CFG_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (rx_tog_o == $past(cfg_rx_tog_i)) && (tx_tog_o == $past(cfg_tx_tog_i))); // R9
endmodule

bind dtog_tracker dtog_tracker_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_we_i     (cfg_we_i),
  .cfg_rx_tog_i (cfg_rx_tog_i),
  .cfg_tx_tog_i (cfg_tx_tog_i),
  .rx_done_i    (rx_done_i),
  .rx_pid_odd_i (rx_pid_odd_i),
  .rx_accept_i  (rx_accept_i),
  .tx_done_i    (tx_done_i),
  .tx_res_i     (tx_res_i),
  .rx_auto_i    (dir_auto[0]),
  .tx_auto_i    (dir_auto[1]),
  .tx_nohs_i    (dir_nohs[1]),
  .rx_tog_o     (rx_tog_o),
  .tx_tog_o     (tx_tog_o),
  .tog_ok_o     (tog_ok_o)
);

// File: tb/test_dtog_tracker.sv
module test_dtog_tracker;
  localparam int unsigned BUF_BYTES = 64;
  localparam int unsigned OFF_W = $clog2(2 * BUF_BYTES);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we_i = 0, cfg_rx_tog_i = 0, cfg_tx_tog_i = 0, cfg_rx_auto_i = 0, cfg_tx_auto_i = 0;
  logic cfg_rx_nohs_i = 0, cfg_tx_nohs_i = 0, cfg_rx_dbl_i = 0, cfg_tx_dbl_i = 0;
  logic rx_done_i = 0, rx_pid_odd_i = 0, rx_accept_i = 0, tx_done_i = 0;
  logic [1:0] tx_res_i = 2'b00;
  logic rx_tog_o, tx_tog_o, tog_ok_o, rx_ack_en_o, tx_ack_wait_o;
  logic [3:0] tx_pid_o;
  logic [OFF_W-1:0] rx_buf_off_o, tx_buf_off_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // model state
  logic m_rtog = 0, m_ttog = 0, m_ok = 0, m_rauto = 0, m_tauto = 0;
  logic m_rnh = 0, m_tnh = 0, m_rdbl = 0, m_tdbl = 0;

  always #5 clk_i = ~clk_i;

  dtog_tracker #(.BUF_BYTES(BUF_BYTES)) i_dtog_tracker (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " R3 tog_ok"}, tog_ok_o, m_ok);
    chk({tag, " R4 rx_tog"}, rx_tog_o, m_rtog);
    chk({tag, " R5 tx_tog"}, tx_tog_o, m_ttog);
    chk({tag, " R6 tx_pid"}, tx_pid_o, m_ttog ? 11 : 3);
    chk({tag, " R7 rx_ack_en"}, rx_ack_en_o, !m_rnh);
    chk({tag, " R7 tx_ack_wait"}, tx_ack_wait_o, !m_tnh);
    chk({tag, " R8 rx_off"}, rx_buf_off_o, (m_rdbl && m_rtog) ? BUF_BYTES : 0);
    chk({tag, " R8 tx_off"}, tx_buf_off_o, (m_tdbl && m_ttog) ? BUF_BYTES : 0);
  endtask

  // one clock edge; inputs driven at negedge, sampled at next negedge
  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic cfg(input logic rt, tt, ra, ta, rn, tn, rd, td);
    cfg_we_i = 1; cfg_rx_tog_i = rt; cfg_tx_tog_i = tt; cfg_rx_auto_i = ra; cfg_tx_auto_i = ta;
    cfg_rx_nohs_i = rn; cfg_tx_nohs_i = tn; cfg_rx_dbl_i = rd; cfg_tx_dbl_i = td;
    tick();
    cfg_we_i = 0;
    m_rtog = rt; m_ttog = tt; m_rauto = ra; m_tauto = ta;
    m_rnh = rn; m_tnh = tn; m_rdbl = rd; m_tdbl = td;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk_all("reset R1");
    rst_ni = 1;
    tick();
    chk_all("post-reset R1");

    // R2: load all fields
    cfg(1, 1, 1, 0, 1, 1, 1, 1);
    chk_all("cfg load R2");
    cfg(0, 0, 0, 0, 0, 0, 0, 0);
    chk_all("cfg clear R2");

    // R3/R4 sweep
    for (int a = 0; a < 2; a++)
      for (int t = 0; t < 2; t++)
        for (int p = 0; p < 2; p++)
          for (int acc = 0; acc < 2; acc++) begin
            cfg(t[0], 0, a[0], 0, a[0], 0, 1, 0);
            rx_done_i = 1; rx_pid_odd_i = p[0]; rx_accept_i = acc[0];
            tick();
            rx_done_i = 0; rx_pid_odd_i = ~p[0]; rx_accept_i = 0;
            m_ok = (p[0] == m_rtog);
            if (m_ok && acc[0] && m_rauto) m_rtog = ~m_rtog;
            chk_all("rx event R3 R4");
            tick();
            chk_all("rx hold R3");
          end

    // R5/R6/R7 sweep
    for (int a = 0; a < 2; a++)
      for (int nh = 0; nh < 2; nh++)
        for (int t = 0; t < 2; t++)
          for (int r = 0; r < 4; r++) begin
            cfg(0, t[0], 0, a[0], 0, nh[0], 0, 1);
            tx_done_i = 1; tx_res_i = r[1:0];
            tick();
            tx_done_i = 0; tx_res_i = 2'b00;
            if (m_tauto && (r == 0 || m_tnh)) m_ttog = ~m_ttog;
            chk_all("tx event R5 R6 R7");
          end

    // R8: all double-buffer/toggle combinations
    for (int d = 0; d < 4; d++)
      for (int t = 0; t < 4; t++) begin
        cfg(t[0], t[1], 0, 0, 0, 0, d[0], d[1]);
        chk_all("buffer half R8");
      end

    // R9: write collides with successful rx and tx
    cfg(0, 0, 1, 1, 0, 0, 0, 0);
    cfg_we_i = 1; cfg_rx_tog_i = 0; cfg_tx_tog_i = 0; cfg_rx_auto_i = 1; cfg_tx_auto_i = 1;
    cfg_rx_nohs_i = 0; cfg_tx_nohs_i = 0; cfg_rx_dbl_i = 0; cfg_tx_dbl_i = 0;
    rx_done_i = 1; rx_pid_odd_i = 0; rx_accept_i = 1;
    tx_done_i = 1; tx_res_i = 2'b00;
    tick();
    cfg_we_i = 0; rx_done_i = 0; rx_accept_i = 0; tx_done_i = 0;
    m_ok = 1;
    chk_all("cfg priority R9");
    // afterwards auto flip resumes
    rx_done_i = 1; rx_pid_odd_i = 0; rx_accept_i = 1; tx_done_i = 1;
    tick();
    rx_done_i = 0; rx_accept_i = 0; tx_done_i = 0;
    m_rtog = 1; m_ttog = 1; m_ok = 1;
    chk_all("flip after R9");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule